// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Packing

This block is the playback side of a single audio channel. Software-facing logic writes sample words into it. Each word becomes one or two FIFO entries. Every entry holds a 20-bit sample that is left-justified and zero-padded at the bottom. A configuration write sets five things:

- the sample width: 12, 16, 18 or 20 bits;
- whether one 32-bit word carries two 16-bit halves (compact packing);
- the transmit enable;
- two slot-select bits;
- (through its two-bit code) the width decoding used for later words.

On the codec side the block hands out stereo pairs over a valid/ready handshake. The left entry is the older of the two. A burst of pairs begins only once the FIFO is at least half full. The burst then continues until fewer than two entries remain. If the sink holds ready low, the offered pair is kept stable and the burst pauses.

The block keeps four status flags: empty, half-empty, full and underrun. Each flag is set or cleared only by the event that the requirements tie it to, so the flags are not a plain function of the fill level. Three interrupt sources follow the flags. A mask combines them into one interrupt line. Dropping the interface enable returns the configuration, the FIFO and the flags to their reset values.

Top module: `pcm_tx_path`

## Requirements
- R1: Width code `ctl_size` decodes as 0 = 16 bits, 1 = 18 bits, 2 = 20 bits and 3 = 12 bits. In one-sample-per-word mode the word is shifted left by (20 - width), and the low 20 bits form one entry. A 20-bit width stores bits 19:0 unshifted.
- R2: In compact mode one accepted word yields two entries. Bits 15:0 are stored first and bits 31:16 second. Each half is shifted left by 8 for the 12-bit width and by 4 for the 16-bit width, then cut to 20 bits.
- R3: If compact mode is requested with width code 1 or 2, the block behaves as in one-sample-per-word mode.
- R4: A one-sample word is accepted only while level < DEPTH. A compact word is accepted only while level + 2 < DEPTH. A word that is not accepted leaves the FIFO contents and level unchanged.
- R5: `snk_valid` rises only when three conditions hold: transmit is enabled, at least one `ctl_slots` bit is set, and level >= DEPTH/2. Pairs leave in write order, with `snk_left` the older entry. The burst continues while two or more entries remain. While ready is low, the offered pair stays stable.
- R6: On the clock edge that accepts a word, the flags update as follows: a nonzero level clears empty and underrun; a level >= DEPTH/2 clears half-empty; a level >= DEPTH sets full. Flags are registered and change on that edge.
- R7: On an edge that removes a pair, full is cleared. Half-empty is set if the level becomes <= DEPTH/2. Empty and underrun are both set if the level becomes 0.
- R8: `int_status` bit 0 reports underrun and bit 1 reports half-empty. Bit 2 reports completion, which means empty while no pair is offered. `irq` is the OR of `int_status & irq_mask`.
- R9: A pulse on `clr_underrun` clears the underrun flag on the next edge, unless that same edge empties the FIFO by a pop.
- R10: While `if_enable` is low, the configuration, the FIFO level and the flags are forced to their reset values.
- R11: After reset, empty and half-empty are 1, full and underrun are 0, `int_status` is 3'b110, and no pair is offered.
- R12: DEPTH defaults to 8, so full rises after exactly 8 single-sample writes. Only 8, 32, 64, 128, 256, 512, 1024 and 2048 are legal; any other value, 16 included, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_enable | input | 1 | Interface enable; low holds everything in reset state |
| ctl_we | input | 1 | Loads the configuration fields below |
| ctl_tx_en | input | 1 | Transmit enable |
| ctl_slots | input | 2 | Slot selects; either bit set permits draining |
| ctl_size | input | 2 | Sample width code (R1) |
| ctl_compact | input | 1 | Request two samples per word |
| wr_valid | input | 1 | Sample word write strobe |
| wr_data | input | 32 | Sample word |
| clr_underrun | input | 1 | Clears the underrun flag |
| irq_mask | input | 3 | Per-source interrupt enable |
| snk_valid | output | 1 | A stereo pair is offered |
| snk_ready | input | 1 | Sink takes the pair |
| snk_left | output | 20 | Older entry of the pair |
| snk_right | output | 20 | Newer entry of the pair |
| st_empty | output | 1 | Empty flag |
| st_half_empty | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |
| int_status | output | 3 | Interrupt sources {complete, half-empty, underrun} |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench sweeps every width code in both packing modes and compares each drained pair with the arithmetic padding. A design that swapped the compact halves, or shifted by the wrong amount, fails on the first pair.

Overflow is driven in both modes. In one-sample mode, writes past DEPTH must vanish. In compact mode, writes must be refused one pair early. A design that compared with <= or ignored the +2 would drain an extra pair.

An odd residue of one entry must stop the burst and keep the FIFO non-empty. The bench also checks that refilling continues correctly across the pointer wrap. A stalled sink must see a frozen pair, and toggling the interface enable must also discard the configuration.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int SAMPLE_W = 20;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_18 = 2'd1,
        SZ_20 = 2'd2,
        SZ_12 = 2'd3
    } size_code_e;

    typedef struct packed {
        logic       tx_en;
        logic [1:0] slots;
        size_code_e size;
        logic       compact;
    } ctl_t;

    typedef struct packed {
        logic empty;
        logic half;
        logic full;
        logic underrun;
    } flags_t;

    localparam flags_t FLAGS_RST = '{empty: 1'b1, half: 1'b1, full: 1'b0, underrun: 1'b0};

    function automatic bit depth_ok(int d);
        return (d == 8) || (d == 32) || (d == 64) || (d == 128) ||
               (d == 256) || (d == 512) || (d == 1024) || (d == 2048);
    endfunction

endpackage

// File: rtl/pcm_sample_packer.sv
module pcm_sample_packer
    import pcm_tx_pkg::*;
(
    input  size_code_e            size,
    input  logic                  compact_eff,
    input  logic [31:0]           word,
    output logic [SAMPLE_W-1:0]   ent0,
    output logic [SAMPLE_W-1:0]   ent1,
    output logic                  two
);

    always_comb begin
        two  = compact_eff;
        ent0 = '0;
        ent1 = '0;
        if (compact_eff) begin
            if (size == SZ_12) begin
                ent0 = {word[11:0], 8'b0};
                ent1 = {word[27:16], 8'b0};
            end else begin
                ent0 = {word[15:0], 4'b0};
                ent1 = {word[31:16], 4'b0};
            end
        end else begin
            unique case (size)
                SZ_16: ent0 = {word[15:0], 4'b0};
                SZ_18: ent0 = {word[17:0], 2'b0};
                SZ_20: ent0 = word[19:0];
                SZ_12: ent0 = {word[11:0], 8'b0};
                default: ent0 = '0;
            endcase
        end
    end

endmodule

// File: rtl/pcm_pair_ring.sv
module pcm_pair_ring #(
    parameter int DEPTH = 8,
    parameter int W     = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         wr_en,
    input  logic         wr_two,
    input  logic [W-1:0] wr_d0,
    input  logic [W-1:0] wr_d1,
    input  logic         rd_pop,
    output logic [W-1:0] rd_d0,
    output logic [W-1:0] rd_d1
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_d, wp_q, rp_d, rp_q;
    logic [AW-1:0] wp_nx, rp_nx;

    always_comb begin
        wp_nx = wp_q + AW'(1);
        rp_nx = rp_q + AW'(1);
        wp_d  = wp_q;
        rp_d  = rp_q;
        if (clear) begin
            wp_d = '0;
            rp_d = '0;
        end else begin
            if (wr_en)  wp_d = wr_two ? wp_q + AW'(2) : wp_nx;
            if (rd_pop) rp_d = rp_q + AW'(2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            wp_q <= wp_d;
            rp_q <= rp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            mem_q[wp_q] <= wr_d0;
            if (wr_two) mem_q[wp_nx] <= wr_d1;
        end
    end

    assign rd_d0 = mem_q[rp_q];
    assign rd_d1 = mem_q[rp_nx];

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
    import pcm_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        if_enable,
    input  logic        ctl_we,
    input  logic        ctl_tx_en,
    input  logic [1:0]  ctl_slots,
    input  logic [1:0]  ctl_size,
    input  logic        ctl_compact,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic        clr_underrun,
    input  logic [2:0]  irq_mask,
    output logic        snk_valid,
    input  logic        snk_ready,
    output logic [19:0] snk_left,
    output logic [19:0] snk_right,
    output logic        st_empty,
    output logic        st_half_empty,
    output logic        st_full,
    output logic        st_underrun,
    output logic [2:0]  int_status,
    output logic        irq
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;
    localparam logic [LW-1:0] LV_DEPTH = LW'(DEPTH);
    localparam logic [LW-1:0] LV_HALF  = LW'(DEPTH / 2);
    localparam logic [LW-1:0] LV_ONE   = LW'(1);
    localparam logic [LW-1:0] LV_TWO   = LW'(2);

    generate
        if (!depth_ok(DEPTH)) begin : g_bad_depth
            $error("pcm_tx_path: DEPTH must be 8 or a power of two from 32 to 2048");
        end
    endgenerate

    typedef struct packed {
        ctl_t          ctl;
        logic [LW-1:0] lvl;
        logic          drain;
        flags_t        fl;
    } state_t;

    state_t s_d, s_q;

    logic                cmp_eff, room, acc, pop, valid_c;
    logic                pk_two;
    logic [SAMPLE_W-1:0] pk_e0, pk_e1;
    logic [LW-1:0]       n_in, lvl_d;

    pcm_sample_packer u_pack (
        .size        (s_q.ctl.size),
        .compact_eff (cmp_eff),
        .word        (wr_data),
        .ent0        (pk_e0),
        .ent1        (pk_e1),
        .two         (pk_two)
    );

    pcm_pair_ring #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!if_enable),
        .wr_en  (acc),
        .wr_two (pk_two),
        .wr_d0  (pk_e0),
        .wr_d1  (pk_e1),
        .rd_pop (pop),
        .rd_d0  (snk_left),
        .rd_d1  (snk_right)
    );

    always_comb begin
        cmp_eff = s_q.ctl.compact && (s_q.ctl.size == SZ_16 || s_q.ctl.size == SZ_12);
        valid_c = s_q.ctl.tx_en && (|s_q.ctl.slots) && (s_q.lvl >= LV_TWO) &&
                  (s_q.drain || s_q.lvl >= LV_HALF);
        pop     = valid_c && snk_ready;
        room    = cmp_eff ? (s_q.lvl < LV_DEPTH - LV_TWO) : (s_q.lvl < LV_DEPTH);
        acc     = wr_valid && room;
        n_in    = acc ? (cmp_eff ? LV_TWO : LV_ONE) : '0;
        lvl_d   = s_q.lvl + n_in - (pop ? LV_TWO : '0);

        s_d       = s_q;
        s_d.lvl   = lvl_d;
        s_d.drain = valid_c && (lvl_d >= LV_TWO);
        if (ctl_we) begin
            s_d.ctl = '{tx_en: ctl_tx_en, slots: ctl_slots,
                        size: size_code_e'(ctl_size), compact: ctl_compact};
        end
        if (acc) begin
            if (lvl_d != '0) begin
                s_d.fl.empty    = 1'b0;
                s_d.fl.underrun = 1'b0;
            end
            if (lvl_d >= LV_HALF)  s_d.fl.half = 1'b0;
            if (lvl_d >= LV_DEPTH) s_d.fl.full = 1'b1;
        end
        if (clr_underrun) s_d.fl.underrun = 1'b0;
        if (pop) begin
            s_d.fl.full = 1'b0;
            if (lvl_d <= LV_HALF) s_d.fl.half = 1'b1;
            if (lvl_d == '0) begin
                s_d.fl.empty    = 1'b1;
                s_d.fl.underrun = 1'b1;
            end
        end
        if (!if_enable) begin
            s_d    = '0;
            s_d.fl = FLAGS_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.fl <= FLAGS_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign snk_valid     = valid_c;
    assign st_empty      = s_q.fl.empty;
    assign st_half_empty = s_q.fl.half;
    assign st_full       = s_q.fl.full;
    assign st_underrun   = s_q.fl.underrun;
    assign int_status    = {s_q.fl.empty && !valid_c, s_q.fl.half, s_q.fl.underrun};
    assign irq           = |(int_status & irq_mask);

endmodule

// File: rtl/pcm_tx_path_chk.sv
module pcm_tx_path_chk #(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          if_enable,
    input logic          ctl_we,
    input logic          wr_valid,
    input logic          clr_underrun,
    input logic [2:0]    irq_mask,
    input logic          snk_valid,
    input logic          snk_ready,
    input logic [19:0]   snk_left,
    input logic [19:0]   snk_right,
    input logic          st_empty,
    input logic          st_full,
    input logic          st_underrun,
    input logic          irq,
    input logic [LW-1:0] lvl
);

    // R4: level never passes the capacity
    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl) <= DEPTH);

    // R5: no pair offered with fewer than two entries
    a_r5_pair_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lvl) < 2) |-> !snk_valid);

    // R5: a stalled pair stays put
    a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (if_enable && snk_valid && !snk_ready && !ctl_we)
        |=> (snk_valid && $stable(snk_left) && $stable(snk_right)));

    // R6: an accepted word leaves the FIFO non-empty
    a_r6_push_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (if_enable && wr_valid && (int'(lvl) + 2 < DEPTH)) |=> !st_empty);

    // R7: removing a pair drops full
    a_r7_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (if_enable && snk_valid && snk_ready) |=> !st_full);

    // R8: a zero mask keeps the line low
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 3'b000) |-> !irq);

    // R9: clear works unless a pop empties the FIFO
    a_r9_clear_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (if_enable && clr_underrun && !(snk_valid && snk_ready)) |=> !st_underrun);

    // R10: disabling the interface restores the idle state
    a_r10_disable_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !if_enable |=> (st_empty && !st_full && !st_underrun && !snk_valid));

endmodule

bind pcm_tx_path pcm_tx_path_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .if_enable    (if_enable),
    .ctl_we       (ctl_we),
    .wr_valid     (wr_valid),
    .clr_underrun (clr_underrun),
    .irq_mask     (irq_mask),
    .snk_valid    (snk_valid),
    .snk_ready    (snk_ready),
    .snk_left     (snk_left),
    .snk_right    (snk_right),
    .st_empty     (st_empty),
    .st_full      (st_full),
    .st_underrun  (st_underrun),
    .irq          (irq),
    .lvl          (s_q.lvl)
);

// File: tb/pcm_tx_path_test.sv
module pcm_tx_path_test;

    localparam int CLK_P = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_enable = 1'b1;
    logic        ctl_we = 1'b0;
    logic        ctl_tx_en = 1'b0;
    logic [1:0]  ctl_slots = '0;
    logic [1:0]  ctl_size = '0;
    logic        ctl_compact = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        clr_underrun = 1'b0;
    logic [2:0]  irq_mask = '0;
    logic        snk_valid;
    logic        snk_ready = 1'b0;
    logic [19:0] snk_left, snk_right;
    logic        st_empty, st_half_empty, st_full, st_underrun;
    logic [2:0]  int_status;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [19:0] m_q [0:15];
    int          m_lvl = 0;
    int          m_code = 0;
    bit          m_cmp = 0;

    always #(CLK_P / 2) clk = ~clk;

    pcm_tx_path #(.DEPTH(DEPTH)) uut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] pad_word(int code, logic [31:0] v);
        int w;
        logic [31:0] t;
        w = (code == 0) ? 16 : (code == 1) ? 18 : (code == 2) ? 20 : 12;
        t = v << (20 - w);
        return t[19:0];
    endfunction

    function automatic logic [19:0] pad_half(int code, logic [15:0] h);
        logic [31:0] t;
        t = {16'b0, h} << ((code == 3) ? 8 : 4);
        return t[19:0];
    endfunction

    task automatic set_ctl(bit en, logic [1:0] slots, int code, bit cmp);
        @(negedge clk);
        ctl_we = 1'b1; ctl_tx_en = en; ctl_slots = slots;
        ctl_size = 2'(code); ctl_compact = cmp;
        @(negedge clk);
        ctl_we = 1'b0;
        m_code = code;
        m_cmp  = cmp && (code == 0 || code == 3);
    endtask

    task automatic push(logic [31:0] v);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = v;
        if (m_cmp) begin
            if (m_lvl + 2 < DEPTH) begin
                m_q[m_lvl]     = pad_half(m_code, v[15:0]);
                m_q[m_lvl + 1] = pad_half(m_code, v[31:16]);
                m_lvl += 2;
            end
        end else if (m_lvl < DEPTH) begin
            m_q[m_lvl] = pad_word(m_code, v);
            m_lvl++;
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // called at a negedge with snk_ready already high
    task automatic pop_check(string tag);
        chk({tag, " valid"}, 32'(snk_valid), 32'd1);
        chk({tag, " left"},  32'(snk_left),  32'(m_q[0]));
        chk({tag, " right"}, 32'(snk_right), 32'(m_q[1]));
        for (int i = 0; i < 14; i++) m_q[i] = m_q[i + 2];
        m_lvl -= 2;
        @(negedge clk);
    endtask

    task automatic drain_all(string tag);
        snk_ready = 1'b1;
        for (int g = 0; g < 20 && snk_valid; g++) pop_check(tag);
        snk_ready = 1'b0;
        chk({tag, " model level"}, 32'(m_lvl < 2), 32'd1);
    endtask

    task automatic clear_ur();
        @(negedge clk);
        clr_underrun = 1'b1;
        @(negedge clk);
        clr_underrun = 1'b0;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 empty", 32'(st_empty), 1);
        chk("R11 half", 32'(st_half_empty), 1);
        chk("R11 full", 32'(st_full), 0);
        chk("R11 underrun", 32'(st_underrun), 0);
        chk("R11 int", 32'(int_status), 32'b110);
        chk("R11 valid", 32'(snk_valid), 0);
        chk("R8 mask zero", 32'(irq), 0);
        irq_mask = 3'b010; #1;
        chk("R8 half source", 32'(irq), 1);
        irq_mask = 3'b001; #1;
        chk("R8 underrun masked", 32'(irq), 0);
        irq_mask = 3'b000;

        // R1 sweep of all width codes, one sample per word
        for (int c = 0; c < 4; c++) begin
            set_ctl(1, 2'b01, c, 0);
            for (int i = 0; i < 3; i++) push(32'hF0E1D2C3 ^ (32'h13572468 * (c * 4 + i)));
            chk("R5 below half", 32'(snk_valid), 0);
            chk("R6 empty cleared", 32'(st_empty), 0);
            chk("R6 half kept", 32'(st_half_empty), 1);
            push(32'hA5C3E1F7 + 32'(c));
            chk("R5 starts at half", 32'(snk_valid), 1);
            chk("R6 half cleared", 32'(st_half_empty), 0);
            drain_all("R1 pair");
            chk("R7 empty set", 32'(st_empty), 1);
            chk("R7 underrun set", 32'(st_underrun), 1);
            chk("R7 half set", 32'(st_half_empty), 1);
            chk("R8 all sources", 32'(int_status), 32'b111);
            irq_mask = 3'b001; #1;
            chk("R8 underrun irq", 32'(irq), 1);
            irq_mask = 3'b000;
            clear_ur();
            chk("R9 underrun cleared", 32'(st_underrun), 0);
        end

        // R2 compact packing, width codes 0 and 3
        for (int k = 0; k < 2; k++) begin
            set_ctl(1, 2'b10, k * 3, 1);
            push(32'h9ABC_1357);
            chk("R2 two entries no drain", 32'(snk_valid), 0);
            push(32'h2468_FEDC);
            chk("R2 level four drains", 32'(snk_valid), 1);
            drain_all("R2 pair");
            clear_ur();
        end

        // R3 compact request with 18/20 bits falls back
        for (int c = 1; c < 3; c++) begin
            set_ctl(1, 2'b01, c, 1);
            push(32'h000C_BA98); push(32'h0003_1416);
            chk("R3 one entry per word", 32'(snk_valid), 0);
            push(32'h0005_9265); push(32'h000F_0F0F);
            chk("R3 four entries", 32'(snk_valid), 1);
            drain_all("R3 pair");
            clear_ur();
        end

        // R4/R12 overflow in one-sample mode, no slot selected
        set_ctl(1, 2'b00, 0, 0);
        for (int i = 0; i < 7; i++) push(32'h100 + 32'(i));
        chk("R12 not full at 7", 32'(st_full), 0);
        push(32'h107);
        chk("R12 full at 8", 32'(st_full), 1);
        push(32'h1FF); push(32'h2FF);
        chk("R5 no slot no drain", 32'(snk_valid), 0);
        set_ctl(1, 2'b10, 0, 0);
        snk_ready = 1'b1;
        pop_check("R4 first pair");
        chk("R7 full cleared", 32'(st_full), 0);
        chk("R7 half still clear", 32'(st_half_empty), 0);
        drain_all("R4 pair");
        chk("R4 extras dropped", 32'(st_empty), 1);
        clear_ur();

        // R4 compact overflow: third word last accepted
        set_ctl(1, 2'b00, 0, 1);
        for (int i = 0; i < 4; i++) push(32'h0101_0202 * (i + 1));
        chk("R4 compact never full", 32'(st_full), 0);
        chk("R4 compact half", 32'(st_half_empty), 0);
        set_ctl(1, 2'b01, 0, 1);
        drain_all("R4 compact pair");
        chk("R4 compact empty", 32'(st_empty), 1);
        clear_ur();

        // R5/R7 odd residue and pointer wrap
        set_ctl(1, 2'b00, 2, 0);
        for (int i = 0; i < 5; i++) push(32'hABC00 + 32'(i));
        set_ctl(1, 2'b11, 2, 0);
        drain_all("R5 odd pair");
        chk("R5 residue stops", 32'(snk_valid), 0);
        chk("R7 residue not empty", 32'(st_empty), 0);
        chk("R7 residue half", 32'(st_half_empty), 1);
        chk("R7 residue no underrun", 32'(st_underrun), 0);
        chk("R8 not complete", 32'(int_status[2]), 0);
        for (int i = 0; i < 3; i++) push(32'h55500 + 32'(i));
        chk("R5 restart", 32'(snk_valid), 1);
        drain_all("R5 wrap pair");
        clear_ur();

        // R5 stall keeps the pair
        for (int i = 0; i < 4; i++) push(32'h7_1000 + 32'(i));
        begin
            logic [19:0] l0;
            l0 = snk_left;
            repeat (3) @(negedge clk);
            chk("R5 stall valid", 32'(snk_valid), 1);
            chk("R5 stall left", 32'(snk_left), 32'(l0));
        end
        drain_all("R5 stall pair");
        clear_ur();

        // R10 interface disable
        set_ctl(1, 2'b00, 0, 0);
        for (int i = 0; i < 3; i++) push(32'h3333 + 32'(i));
        @(negedge clk); if_enable = 1'b0;
        @(negedge clk); if_enable = 1'b1;
        m_lvl = 0; m_code = 0; m_cmp = 0;
        chk("R10 empty", 32'(st_empty), 1);
        chk("R10 half", 32'(st_half_empty), 1);
        chk("R10 full", 32'(st_full), 0);
        for (int i = 0; i < 4; i++) push(32'h4440 + 32'(i));
        chk("R10 config cleared", 32'(snk_valid), 0);
        set_ctl(1, 2'b01, 0, 0);
        drain_all("R10 after enable");
        chk("R10 final empty", 32'(st_empty), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule